// File: doc/BRIEF.md
# Timer count-clock and edge selector

This block sits in front of a 16-bit timer/event counter. It decides when the counter advances and when a capture should be taken. An 8-bit mode register holds a count-source select and a polarity code for each of two external inputs. The count source is one of three prescaled taps of the system clock or the active edge of external input 0. All outputs are single-cycle strobes in the system-clock domain. No derived clocks are generated.

Each external input goes through a two-flop synchronizer and then a filter that samples on a strobe. The filter only accepts a new level once three consecutive samples agree. A polarity-selectable edge detector follows the filter. The previous-level register of the edge detector has two start behaviours. On the first start after reset it keeps its reset value of low, so an input that is already high gives a rising event. On any later start it is loaded from the present input level, so a steady level gives no event.

The counter, the compare logic and the capture registers are outside this block.

Top module: `tmr_clk_sel`

## Requirements
- R1: After reset, `mode_o` reads 00h and `cnt_en_o`, `ev0_o` and `ev1_o` are low.
- R2: A write on `mode_we_i` is taken only while `run_i` is low, and a write with `run_i` high leaves `mode_o` unchanged. Bits 3:2 of `mode_o` always read 0. The layout is: bits 7:6 hold the input-1 edge code, bits 5:4 hold the input-0 edge code, and bits 1:0 hold the count select.
- R3: The prescaler is held at zero while the block is stopped. With count select 00, 01 or 10, `cnt_en_o` pulses once every 2, 4 or 64 cycles respectively. Cycle 0 is the first cycle after the clock edge that samples `run_i` high, and the first pulse falls in cycle 1, 3 or 63.
- R4: With count select 11, `cnt_en_o` equals `ev0_o`.
- R5: Edge codes: 00 selects the falling edge, 01 the rising edge and 11 both edges. Each accepted transition of the matching kind gives exactly one event pulse.
- R6: Edge code 10 produces no events for that input.
- R7: When count select is 11, both inputs are sampled every 8 cycles. A level must be seen on three consecutive samples to be accepted, so an 8-cycle pulse is rejected and a 40-cycle pulse is accepted.
- R8: For count selects 00, 01 and 10, the inputs are sampled on the selected tap strobe. With select 00 a 2-cycle pulse is rejected and a 20-cycle pulse is accepted. With select 10 a 64-cycle pulse is rejected and a 320-cycle pulse is accepted.
- R9: On the first start after reset, an input that is already high gives one rising event.
- R10: On a later start, an input that stayed high gives no rising event.
- R11: Every output is a single-cycle pulse, and all outputs stay low while `run_i` was low at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Timer running |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_o | output | 8 | Mode register contents |
| ext0_i | input | 1 | External input 0 (count / capture) |
| ext1_i | input | 1 | External input 1 (capture) |
| cnt_en_o | output | 1 | Count-enable strobe |
| ev0_o | output | 1 | Edge event, input 0 |
| ev1_o | output | 1 | Edge event, input 1 |

## Verification
A table of pulse trains is applied to each input under every edge code, at widths below and above the filter threshold, for both the 8-cycle sample rate and the tap-driven sample rates. The counted events separate rising, falling and both-edge detection from one another and from the reserved code. The counts also show whether the filter is paced by the right strobe. Directed runs on each prescaler tap measure both the pulse rate and the phase of the first pulse after start. Together these confirm that the prescaler restarts from zero. A mid-run reset followed by two starts with input 1 held high tells the first-start behaviour apart from the reload behaviour.

// File: rtl/tmr_sel_pkg.sv
package tmr_sel_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    CKS_DIV_LO  = 2'b00,
    CKS_DIV_MID = 2'b01,
    CKS_DIV_HI  = 2'b10,
    CKS_EXT     = 2'b11
  } cks_e;

  typedef struct packed {
    edge_sel_e  es1;
    edge_sel_e  es0;
    logic [1:0] rsvd;
    cks_e       cks;
  } mode_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CW       = 6,
  parameter int unsigned NTAP     = 4,
  parameter logic [NTAP*8-1:0] TAP_LOG = {8'd3, 8'd6, 8'd2, 8'd1}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic [NTAP-1:0] stb_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // tap k strobes once per 2**TAP_LOG[k] cycles, at all-ones of its low bits
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam int unsigned L = int'(TAP_LOG[k*8 +: 8]);
    assign stb_o[k] = en_i & (&cnt_q[L-1:0]);
  end
endmodule

// File: rtl/tmr_edge_chan.sv
module tmr_edge_chan
  import tmr_sel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_SAMPLES = 3   // >= 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      raw_i,
  input  logic      smp_i,
  input  logic      load_i,
  input  logic      act_i,
  input  edge_sel_e sel_i,
  output logic      ev_o
);
  localparam int unsigned HW = FILT_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q;
  logic                   filt_q, prev_q, lvl, agree, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign lvl   = sync_q[SYNC_STAGES-1];
  assign agree = lvl ? (&hist_q) : ~(|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else if (load_i) begin
      hist_q <= {HW{lvl}};
      filt_q <= lvl;
    end else if (smp_i) begin
      hist_q <= (hist_q << 1) | HW'(lvl);
      if (agree) filt_q <= lvl;
    end
  end

  // reset value low gives the first-start rising event; reload suppresses it later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (load_i) prev_q <= lvl;
    else if (act_i)  prev_q <= filt_q;
  end

  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_FALL: ev_o = act_i & fall;
      EDGE_RISE: ev_o = act_i & rise;
      EDGE_BOTH: ev_o = act_i & (rise | fall);
      default:   ev_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_sel_pkg::*;
#(
  parameter int unsigned DIV_LO_LOG   = 1,
  parameter int unsigned DIV_MID_LOG  = 2,
  parameter int unsigned DIV_HI_LOG   = 6,
  parameter int unsigned SMP_LOG      = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_SAMPLES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       mode_we_i,
  input  logic [7:0] mode_wdata_i,
  output logic [7:0] mode_o,
  input  logic       ext0_i,
  input  logic       ext1_i,
  output logic       cnt_en_o,
  output logic       ev0_o,
  output logic       ev1_o
);
  localparam int unsigned NTAP = 4;
  localparam logic [NTAP*8-1:0] TAPS = {8'(SMP_LOG), 8'(DIV_HI_LOG),
                                        8'(DIV_MID_LOG), 8'(DIV_LO_LOG)};

  mode_t           mode_q;
  logic            run_q, started_q, start, load, tap, smp;
  logic [NTAP-1:0] stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (mode_we_i && !run_i)
      mode_q <= '{es1:  edge_sel_e'(mode_wdata_i[7:6]),
                  es0:  edge_sel_e'(mode_wdata_i[5:4]),
                  rsvd: 2'b00,
                  cks:  cks_e'(mode_wdata_i[1:0])};
  end

  assign start = run_i & ~run_q;
  assign load  = start & started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (start) started_q <= 1'b1;
    end
  end

  tmr_prescaler #(
    .CW(DIV_HI_LOG), .NTAP(NTAP), .TAP_LOG(TAPS)
  ) u_presc (
    .clk_i, .rst_ni, .en_i(run_q), .stb_o(stb)
  );

  always_comb begin
    unique case (mode_q.cks)
      CKS_DIV_LO:  tap = stb[0];
      CKS_DIV_MID: tap = stb[1];
      CKS_DIV_HI:  tap = stb[2];
      default:     tap = 1'b0;
    endcase
  end

  assign smp = (mode_q.cks == CKS_EXT) ? stb[3] : tap;

  tmr_edge_chan #(.SYNC_STAGES(SYNC_STAGES), .FILT_SAMPLES(FILT_SAMPLES)) u_ch0 (
    .clk_i, .rst_ni, .raw_i(ext0_i), .smp_i(smp), .load_i(load),
    .act_i(run_q), .sel_i(mode_q.es0), .ev_o(ev0_o)
  );

  tmr_edge_chan #(.SYNC_STAGES(SYNC_STAGES), .FILT_SAMPLES(FILT_SAMPLES)) u_ch1 (
    .clk_i, .rst_ni, .raw_i(ext1_i), .smp_i(smp), .load_i(load),
    .act_i(run_q), .sel_i(mode_q.es1), .ev_o(ev1_o)
  );

  assign cnt_en_o = (mode_q.cks == CKS_EXT) ? ev0_o : tap;
  assign mode_o   = mode_q;
endmodule

// File: rtl/tmr_clk_sel_chk.sv
module tmr_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic [7:0] mode_o,
  input logic       cnt_en_o,
  input logic       ev0_o,
  input logic       ev1_o
);
  p_mode_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(mode_o));

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[3:2] == 2'b00);

  p_ext_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1:0] == 2'b11) |-> (cnt_en_o == ev0_o));

  p_no_edge0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[5:4] == 2'b10) |-> !ev0_o);

  p_no_edge1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[7:6] == 2'b10) |-> !ev1_o);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !(cnt_en_o | ev0_o | ev1_o));

  p_cnt_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |=> !cnt_en_o);

  p_ev0_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev0_o |=> !ev0_o);

  p_ev1_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev1_o |=> !ev1_o);
endmodule

bind tmr_clk_sel tmr_clk_sel_chk u_chk (
  .clk_i, .rst_ni, .run_i, .mode_o, .cnt_en_o, .ev0_o, .ev1_o
);

// File: tb/tb_tmr_clk_sel.sv
module tb_tmr_clk_sel;
  localparam int CLK_P = 10;
  localparam int NPULSE = 3;

  typedef struct packed {
    logic [7:0] mode;
    logic       ch;
    logic [8:0] width;
    logic [8:0] gap;
    logic [7:0] exp_cnt;   // FF: not checked
    logic [7:0] exp_ev0;
    logic [7:0] exp_ev1;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'h13, 1'b0, 9'd64,  9'd64,  8'd3,   8'd3, 8'd0},  // R5 rise, R4
    '{8'h03, 1'b0, 9'd64,  9'd64,  8'd3,   8'd3, 8'd0},  // R5 fall
    '{8'h33, 1'b0, 9'd64,  9'd64,  8'd6,   8'd6, 8'd0},  // R5 both
    '{8'h23, 1'b0, 9'd64,  9'd64,  8'd0,   8'd0, 8'd0},  // R6
    '{8'h13, 1'b0, 9'd8,   9'd64,  8'd0,   8'd0, 8'd0},  // R7 reject
    '{8'h13, 1'b0, 9'd40,  9'd64,  8'd3,   8'd3, 8'd0},  // R7 accept
    '{8'h40, 1'b1, 9'd20,  9'd64,  8'hFF,  8'd0, 8'd3},  // R8 accept
    '{8'h40, 1'b1, 9'd2,   9'd64,  8'hFF,  8'd0, 8'd0},  // R8 reject
    '{8'hC0, 1'b1, 9'd20,  9'd64,  8'hFF,  8'd0, 8'd6},  // R5 both, input 1
    '{8'h80, 1'b1, 9'd20,  9'd64,  8'hFF,  8'd0, 8'd0},  // R6 input 1
    '{8'h12, 1'b0, 9'd64,  9'd256, 8'hFF,  8'd0, 8'd0},  // R8 div64 reject
    '{8'h12, 1'b0, 9'd320, 9'd320, 8'hFF,  8'd3, 8'd0}   // R8 div64 accept
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [7:0] mode_wdata_i = 8'h00;
  logic       ext0_i = 1'b0;
  logic       ext1_i = 1'b0;
  logic [7:0] mode_o;
  logic       cnt_en_o, ev0_o, ev1_o;

  int checks = 0;
  int failures = 0;
  int n_cnt = 0, n_ev0 = 0, n_ev1 = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  tmr_clk_sel dut (
    .clk_i, .rst_ni, .run_i, .mode_we_i, .mode_wdata_i, .mode_o,
    .ext0_i, .ext1_i, .cnt_en_o, .ev0_o, .ev1_o
  );

  always @(negedge clk_i) begin
    if (cnt_en_o) n_cnt <= n_cnt + 1;
    if (ev0_o)    n_ev0 <= n_ev0 + 1;
    if (ev1_o)    n_ev1 <= n_ev1 + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk_i);
    mode_we_i = 1'b1;
    mode_wdata_i = v;
    @(negedge clk_i);
    mode_we_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    run_i = 1'b0;
    cycles(3);
    rst_ni = 1'b1;
    cycles(2);
  endtask

  task automatic tap_test(input logic [7:0] m, input int exp_n, input int exp_first, input string req);
    int n = 0;
    int first = -1;
    run_i = 1'b0;
    cycles(3);
    write_mode(m);
    run_i = 1'b1;
    @(posedge clk_i);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk_i);
      if (cnt_en_o) begin
        n++;
        if (first < 0) first = i;
      end
    end
    check({req, " tap count"}, n, exp_n);
    check({req, " first pulse"}, first, exp_first);
    @(negedge clk_i);
    run_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int c0, e0, e1;
    @(negedge clk_i);
    run_i = 1'b0;
    ext0_i = 1'b0;
    ext1_i = 1'b0;
    cycles(8);
    write_mode(v.mode);
    @(posedge clk_i);
    c0 = n_cnt; e0 = n_ev0; e1 = n_ev1;
    @(negedge clk_i);
    run_i = 1'b1;
    cycles(16);
    for (int p = 0; p < NPULSE; p++) begin
      if (v.ch) ext1_i = 1'b1; else ext0_i = 1'b1;
      cycles(int'(v.width));
      ext0_i = 1'b0;
      ext1_i = 1'b0;
      cycles(int'(v.gap));
    end
    cycles(32);
    run_i = 1'b0;
    cycles(2);
    @(posedge clk_i);
    if (v.exp_cnt != 8'hFF)
      check($sformatf("R4/R5/R7 vec%0d cnt_en", idx), n_cnt - c0, int'(v.exp_cnt));
    check($sformatf("R5/R6/R7/R8 vec%0d ev0", idx), n_ev0 - e0, int'(v.exp_ev0));
    check($sformatf("R5/R6/R8 vec%0d ev1", idx), n_ev1 - e1, int'(v.exp_ev1));
  endtask

  initial begin
    int c0, e0, e1;
    cycles(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 mode", int'(mode_o), 0);
    check("R1 outputs", int'({cnt_en_o, ev0_o, ev1_o}), 0);

    // R2 write gating and reserved bits
    write_mode(8'hFF);
    @(negedge clk_i);
    check("R2 stopped write", int'(mode_o), 8'hF3);
    run_i = 1'b1;
    cycles(2);
    write_mode(8'h00);
    @(negedge clk_i);
    check("R2 running write ignored", int'(mode_o), 8'hF3);
    run_i = 1'b0;
    cycles(2);

    // R3 prescaler taps
    tap_test(8'h00, 64, 1,  "R3 div2");
    tap_test(8'h01, 32, 3,  "R3 div4");
    tap_test(8'h02, 2,  63, "R3 div64");

    // R11 stopped: no strobes while toggling inputs
    write_mode(8'h33);
    @(posedge clk_i);
    c0 = n_cnt; e0 = n_ev0; e1 = n_ev1;
    @(negedge clk_i);
    ext0_i = 1'b1; ext1_i = 1'b1;
    cycles(40);
    ext0_i = 1'b0; ext1_i = 1'b0;
    cycles(40);
    @(posedge clk_i);
    check("R11 idle outputs", (n_cnt - c0) + (n_ev0 - e0) + (n_ev1 - e1), 0);

    // table of pulse trains
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R9 / R10 first start versus restart
    do_reset();
    check("R1 mode after reset", int'(mode_o), 0);
    write_mode(8'h40);
    ext1_i = 1'b1;
    cycles(10);
    @(posedge clk_i);
    e1 = n_ev1;
    @(negedge clk_i);
    run_i = 1'b1;
    cycles(64);
    run_i = 1'b0;
    cycles(2);
    @(posedge clk_i);
    check("R9 first start rising", n_ev1 - e1, 1);
    e1 = n_ev1;
    cycles(10);
    run_i = 1'b1;
    cycles(64);
    run_i = 1'b0;
    cycles(2);
    @(posedge clk_i);
    check("R10 restart no event", n_ev1 - e1, 0);
    ext1_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule